// File: doc/BRIEF.md
# Shared Interrupt Target Router

This block keeps the CPU routing of every shared interrupt in an interrupt distributor and works out, for each CPU, whether at least one enabled interrupt is waiting for it. Software reaches the routing through a word-wide register window. Each word covers four interrupts, one byte per interrupt. The words that cover the 32 private interrupts of each CPU are read-only. A read of one of them returns the accessing CPU's own one-hot bit in every byte.

Each shared interrupt goes to exactly one CPU. A write picks the lowest set bit of the byte as the target. A byte that names no existing CPU routes the interrupt to CPU0. The register bank that owns the enable and pending state supplies those vectors together with the distributor's global enable. It also raises `state_changed` for one cycle when any of them moves. The router then refreshes a registered per-CPU pending vector. Choosing among interrupts by priority, and acknowledging them, belong to other blocks.

Top module: `irq_target_router`

## Requirements
- R1: After reset every shared interrupt targets CPU0 (`tgt_onehot` bit 0 of each group set) and `cpu_pending` is all zero.
- R2: A read of a word with index below 8 returns the reading CPU's one-hot bit (bit `acc_cpu`) repeated in all four bytes.
- R3: A write to a word with index below 8 changes no routing: `tgt_onehot` and all read-back values stay as before.
- R4: A write to word w (w >= 8) routes shared interrupt 4*(w-8)+b to the CPU given by the lowest set bit of data byte b (bits 8b+7..8b). Only bit positions below NUM_CPUS count. A byte with no such bit selects CPU0.
- R5: Byte b of a read of shared word w is one-hot, with only bit k set, where k is the CPU that shared interrupt 4*(w-8)+b targets. `tgt_onehot[i*NUM_CPUS+k]` shows the same routing for shared interrupt i.
- R6: CPU c is flagged pending when some bit j has both `pend_priv[c*32+j]` and `en_priv[c*32+j]` set.
- R7: CPU c is flagged pending when some shared interrupt i has `pend_shared[i]` and `en_shared[i]` set and targets c.
- R8: While `dist_en` is 0, every refresh drives all of `cpu_pending` to 0.
- R9: `cpu_pending` is refreshed at the clock edge that samples `state_changed` high or a shared-word write, so it shows the new value one cycle later. A write uses the routing it installs. At all other edges the vector holds.
- R10: A shared write changes only the four interrupts of the addressed word. With no write, routing holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Register access in this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_word | input | $clog2(NUM_IRQS/4) | Word index inside the target window |
| acc_cpu | input | CPU_W | ID of the accessing CPU |
| acc_wdata | input | 32 | Write data, byte b for interrupt 4w+b |
| acc_rdata | output | 32 | Read data, same cycle, 0 when not reading |
| state_changed | input | 1 | Pulse: enable, pending or global enable moved |
| dist_en | input | 1 | Global distributor enable |
| pend_priv | input | NUM_CPUS*32 | Banked pending bits, 32 per CPU |
| en_priv | input | NUM_CPUS*32 | Banked enable bits, 32 per CPU |
| pend_shared | input | NUM_IRQS-32 | Pending bit per shared interrupt |
| en_shared | input | NUM_IRQS-32 | Enable bit per shared interrupt |
| tgt_onehot | output | (NUM_IRQS-32)*NUM_CPUS | One-hot target CPU per shared interrupt |
| cpu_pending | output | NUM_CPUS | Registered pending flag per CPU |

## Verification
The assertions assume that `acc_cpu` names an existing CPU. They also assume that the register bank pulses `state_changed` whenever a pending, enable or global-enable input changes. The hold property on `cpu_pending` relies on that second point. The bench only changes those vectors in a cycle where it also raises `state_changed`, except in one directed hold test that checks the output keeps its old value. The random accesses draw `acc_cpu` below NUM_CPUS and word indices from the full window.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    // Lowest set bit of a routing byte among the first ncpu positions;
    // zero when none is set.
    function automatic logic [2:0] pick_cpu(logic [7:0] b, int unsigned ncpu);
        logic [2:0] r;
        r = 3'd0;
        for (int i = 7; i >= 0; i--) begin
            if (b[i] && (i < int'(ncpu))) r = 3'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_tgt_store.sv
module irq_tgt_store
    import irq_router_pkg::*;
#(
    parameter int NUM_CPUS = 4,
    parameter int NUM_IRQS = 64,
    parameter int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
    parameter int WW       = $clog2(NUM_IRQS / 4)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [WW-1:0]                wr_word,
    input  logic [31:0]                  wr_data,
    input  logic [WW-1:0]                rd_word,
    input  logic [CPU_W-1:0]             rd_cpu,
    output logic [31:0]                  rd_data,
    output logic                         shared_wr,
    output logic [(NUM_IRQS-32)*NUM_CPUS-1:0] tgt_onehot,
    output logic [(NUM_IRQS-32)*NUM_CPUS-1:0] tgt_next_onehot
);
    localparam int NSH        = NUM_IRQS - 32;
    localparam int PRIV_WORDS = 8;
    localparam logic [WW-1:0] PRIV_LIM = WW'(PRIV_WORDS);

    typedef struct packed {
        logic [NSH-1:0][CPU_W-1:0] sel;
    } tgt_state_t;

    tgt_state_t st_d, st_q;

    assign shared_wr = wr_en && (wr_word >= PRIV_LIM);

    always_comb begin
        logic [2:0] pk;
        st_d = st_q;
        pk   = 3'd0;
        if (shared_wr) begin
            for (int i = 0; i < NSH; i++) begin
                if ((i / 4) == (int'(wr_word) - PRIV_WORDS)) begin
                    pk = pick_cpu(wr_data[(i % 4) * 8 +: 8], NUM_CPUS);
                    st_d.sel[i] = pk[CPU_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < NSH; i++) begin : g_irq
        for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
            assign tgt_onehot[i*NUM_CPUS+c]      = (st_q.sel[i] == CPU_W'(c));
            assign tgt_next_onehot[i*NUM_CPUS+c] = (st_d.sel[i] == CPU_W'(c));
        end
    end

    always_comb begin
        logic [7:0] own;
        own     = 8'(1) << rd_cpu;
        rd_data = '0;
        if (rd_word < PRIV_LIM) begin
            rd_data = {4{own}};
        end else begin
            for (int i = 0; i < NSH; i++) begin
                if ((i / 4) == (int'(rd_word) - PRIV_WORDS))
                    rd_data[(i % 4) * 8 +: 8] = 8'(1) << st_q.sel[i];
            end
        end
    end

    // R3: writes to banked words leave the routing untouched
    property p_priv_ro_r3;
        @(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_word < PRIV_LIM)) |=> $stable(tgt_onehot);
    endproperty
    a_priv_ro_r3: assert property (p_priv_ro_r3);

    // R10: no write, no routing change
    property p_tgt_hold_r10;
        @(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(tgt_onehot);
    endproperty
    a_tgt_hold_r10: assert property (p_tgt_hold_r10);

    // R4: a byte with bit 0 set always lands on CPU0
    for (genvar i = 0; i < NSH; i++) begin : g_chk
        property p_low_bit_r4;
            @(posedge clk) disable iff (!rst_n)
            (shared_wr && (int'(wr_word) - PRIV_WORDS == i / 4) && wr_data[(i % 4) * 8])
                |=> tgt_onehot[i*NUM_CPUS];
        endproperty
        a_low_bit_r4: assert property (p_low_bit_r4);
    end

endmodule

// File: rtl/irq_pend_eval.sv
module irq_pend_eval #(
    parameter int NUM_CPUS = 4,
    parameter int NUM_IRQS = 64
) (
    input  logic [NUM_CPUS*32-1:0]            pend_priv,
    input  logic [NUM_CPUS*32-1:0]            en_priv,
    input  logic [NUM_IRQS-33:0]              pend_shared,
    input  logic [NUM_IRQS-33:0]              en_shared,
    input  logic [(NUM_IRQS-32)*NUM_CPUS-1:0] tgt_onehot,
    input  logic                              dist_en,
    output logic [NUM_CPUS-1:0]               pend_now
);
    localparam int NSH = NUM_IRQS - 32;

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        logic priv_hit;
        logic sh_hit;
        assign priv_hit = |(pend_priv[c*32 +: 32] & en_priv[c*32 +: 32]);
        always_comb begin
            sh_hit = 1'b0;
            for (int i = 0; i < NSH; i++)
                sh_hit = sh_hit | (pend_shared[i] & en_shared[i] & tgt_onehot[i*NUM_CPUS+c]);
        end
        assign pend_now[c] = dist_en & (priv_hit | sh_hit);
    end

endmodule

// File: rtl/irq_target_router.sv
module irq_target_router #(
    parameter int NUM_CPUS = 4,
    parameter int NUM_IRQS = 64,
    parameter int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
    parameter int WW       = $clog2(NUM_IRQS / 4)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              acc_valid,
    input  logic                              acc_write,
    input  logic [WW-1:0]                     acc_word,
    input  logic [CPU_W-1:0]                  acc_cpu,
    input  logic [31:0]                       acc_wdata,
    output logic [31:0]                       acc_rdata,
    input  logic                              state_changed,
    input  logic                              dist_en,
    input  logic [NUM_CPUS*32-1:0]            pend_priv,
    input  logic [NUM_CPUS*32-1:0]            en_priv,
    input  logic [NUM_IRQS-33:0]              pend_shared,
    input  logic [NUM_IRQS-33:0]              en_shared,
    output logic [(NUM_IRQS-32)*NUM_CPUS-1:0] tgt_onehot,
    output logic [NUM_CPUS-1:0]               cpu_pending
);
    localparam int NT = (NUM_IRQS - 32) * NUM_CPUS;

    typedef struct packed {
        logic [NUM_CPUS-1:0] pend;
    } pend_state_t;

    pend_state_t         ps_d, ps_q;
    logic [31:0]         rd_raw;
    logic                shared_wr;
    logic [NT-1:0]       tgt_next;
    logic [NUM_CPUS-1:0] pend_now;

    irq_tgt_store #(
        .NUM_CPUS(NUM_CPUS), .NUM_IRQS(NUM_IRQS), .CPU_W(CPU_W), .WW(WW)
    ) u_store (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (acc_valid && acc_write),
        .wr_word        (acc_word),
        .wr_data        (acc_wdata),
        .rd_word        (acc_word),
        .rd_cpu         (acc_cpu),
        .rd_data        (rd_raw),
        .shared_wr      (shared_wr),
        .tgt_onehot     (tgt_onehot),
        .tgt_next_onehot(tgt_next)
    );

    irq_pend_eval #(.NUM_CPUS(NUM_CPUS), .NUM_IRQS(NUM_IRQS)) u_eval (
        .pend_priv  (pend_priv),
        .en_priv    (en_priv),
        .pend_shared(pend_shared),
        .en_shared  (en_shared),
        .tgt_onehot (tgt_next),
        .dist_en    (dist_en),
        .pend_now   (pend_now)
    );

    assign acc_rdata = (acc_valid && !acc_write) ? rd_raw : 32'd0;

    always_comb begin
        ps_d = ps_q;
        if (state_changed || shared_wr) ps_d.pend = pend_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ps_q <= '0;
        else        ps_q <= ps_d;
    end

    assign cpu_pending = ps_q.pend;

    // R9: without a refresh trigger the flags hold
    property p_hold_r9;
        @(posedge clk) disable iff (!rst_n)
        !(state_changed || (acc_valid && acc_write && (int'(acc_word) >= 8)))
            |=> $stable(cpu_pending);
    endproperty
    a_hold_r9: assert property (p_hold_r9);

    // R8: global disable clears every flag on refresh
    property p_off_r8;
        @(posedge clk) disable iff (!rst_n)
        (state_changed && !dist_en) |=> (cpu_pending == '0);
    endproperty
    a_off_r8: assert property (p_off_r8);

    // R6: an enabled banked pending bit flags its CPU
    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_chk
        property p_priv_pend_r6;
            @(posedge clk) disable iff (!rst_n)
            (state_changed && dist_en && |(pend_priv[c*32 +: 32] & en_priv[c*32 +: 32]))
                |=> cpu_pending[c];
        endproperty
        a_priv_pend_r6: assert property (p_priv_pend_r6);
    end

endmodule

// File: tb/irq_target_router_tb_top.sv
`timescale 1ns/1ps
module irq_target_router_tb_top;
    localparam int N   = 4;
    localparam int NI  = 64;
    localparam int NSH = NI - 32;
    localparam int NW  = NI / 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0, acc_write = 1'b0;
    logic [3:0] acc_word = '0;
    logic [1:0] acc_cpu = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic state_changed = 1'b0, dist_en = 1'b0;
    logic [N*32-1:0] pend_priv = '0, en_priv = '0;
    logic [NSH-1:0] pend_shared = '0, en_shared = '0;
    logic [NSH*N-1:0] tgt_onehot;
    logic [N-1:0] cpu_pending;

    int checks = 0, failures = 0;
    bit done = 1'b0;
    int tgt_m [NSH];
    logic [N-1:0] exp_pend = '0;

    always #2.5 clk = ~clk;

    irq_target_router dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_word(acc_word), .acc_cpu(acc_cpu), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .state_changed(state_changed), .dist_en(dist_en),
        .pend_priv(pend_priv), .en_priv(en_priv), .pend_shared(pend_shared),
        .en_shared(en_shared), .tgt_onehot(tgt_onehot), .cpu_pending(cpu_pending)
    );

    function automatic int pick(logic [7:0] b);
        for (int i = 0; i < N; i++) if (b[i]) return i;
        return 0;
    endfunction

    function automatic logic [31:0] exp_word(int w, int cpu);
        logic [31:0] r;
        if (w < 8) return {4{8'(1) << cpu}};
        for (int b = 0; b < 4; b++) r[b*8 +: 8] = 8'(1) << tgt_m[(w-8)*4+b];
        return r;
    endfunction

    function automatic logic [N-1:0] exp_pend_calc();
        logic [N-1:0] r = '0;
        for (int c = 0; c < N; c++) begin
            if (|(pend_priv[c*32 +: 32] & en_priv[c*32 +: 32])) r[c] = 1'b1;
            for (int i = 0; i < NSH; i++)
                if (pend_shared[i] && en_shared[i] && tgt_m[i] == c) r[c] = 1'b1;
        end
        return dist_en ? r : '0;
    endfunction

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(int w, logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_word = 4'(w); acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        if (w >= 8) begin
            for (int b = 0; b < 4; b++) tgt_m[(w-8)*4+b] = pick(d[b*8 +: 8]);
            exp_pend = exp_pend_calc();
        end
    endtask

    task automatic do_read(string req, int w, int cpu);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_word = 4'(w); acc_cpu = 2'(cpu);
        #1;
        check(req, 128'(acc_rdata), 128'(exp_word(w, cpu)));
        acc_valid = 1'b0;
    endtask

    task automatic check_tgt(string req);
        logic [NSH*N-1:0] e = '0;
        for (int i = 0; i < NSH; i++) e[i*N + tgt_m[i]] = 1'b1;
        check(req, 128'(tgt_onehot), 128'(e));
    endtask

    task automatic refresh(string req);
        @(negedge clk);
        state_changed = 1'b1;
        @(negedge clk);
        state_changed = 1'b0;
        exp_pend = exp_pend_calc();
        check(req, 128'(cpu_pending), 128'(exp_pend));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < NSH; i++) tgt_m[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_tgt("R1");
        check("R1", 128'(cpu_pending), 128'(0));
        // R2 private words for every CPU
        for (int c = 0; c < N; c++) do_read("R2", c % 8, c);
        do_read("R2", 7, 3);
        // R3 private write ignored
        do_write(2, 32'h0808_0808);
        check_tgt("R3");
        do_read("R3", 2, 1);
        do_read("R3", 8, 0);
        // R4 directed bytes: 0x0C->2, 0xF0->0 (no bit below N), 0x02->1, 0x00->0
        do_write(9, 32'h0002_F00C);
        do_read("R4", 9, 0);
        check_tgt("R4");
        // R10 neighbour words untouched
        do_read("R10", 8, 0);
        do_read("R10", 10, 0);
        do_write(15, 32'h0801_0408);
        do_read("R5", 15, 2);
        check_tgt("R5");
        // random writes then full read-back
        for (int k = 0; k < 60; k++) do_write(8 + ($urandom % 8), $urandom);
        for (int w = 0; w < NW; w++) do_read("R5", w, $urandom % N);
        check_tgt("R5");
        // R6 private pending
        dist_en = 1'b1;
        pend_priv = '0; en_priv = '0;
        pend_priv[2*32+5] = 1'b1; en_priv[2*32+5] = 1'b1;
        pend_priv[1*32+6] = 1'b1;
        refresh("R6");
        // R7 shared pending routed by target
        pend_priv = '0; en_priv = '0;
        do_write(8, 32'h0000_0008);
        pend_shared = '0; en_shared = '0;
        pend_shared[0] = 1'b1; en_shared[0] = 1'b1;
        refresh("R7");
        check("R7", 128'(cpu_pending), 128'(4'b1000));
        // R9: target write refreshes with the new routing
        do_write(8, 32'h0000_0002);
        check("R9", 128'(cpu_pending), 128'(4'b0010));
        // R9: input change without trigger holds
        @(negedge clk);
        en_shared = '0;
        @(negedge clk);
        @(negedge clk);
        check("R9", 128'(cpu_pending), 128'(4'b0010));
        refresh("R9");
        // random pending patterns
        for (int k = 0; k < 40; k++) begin
            pend_shared = $urandom; en_shared = $urandom;
            for (int c = 0; c < N; c++) begin
                pend_priv[c*32 +: 32] = $urandom & $urandom;
                en_priv[c*32 +: 32]   = $urandom & $urandom & $urandom;
            end
            refresh((k % 2) ? "R7" : "R6");
        end
        // R8 global disable
        pend_shared = '1; en_shared = '1;
        dist_en = 1'b0;
        refresh("R8");
        check("R8", 128'(cpu_pending), 128'(0));
        dist_en = 1'b1;
        refresh("R8");
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule